// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. It takes one single-word read or write request at a time over a valid/ready handshake. It then plays out the RAM control waveform: two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. It also owns the enable of the shared data bus drivers. Each timing interval is an integer count of clock cycles, chosen at elaboration from the RAM speed grade and the clock period. The defaults suit a 10 ns clock and the fastest grade.

A read selects the RAM with the output enable low and the strobe high. It holds that state for the longer of the access time and the minimum cycle time. On the last edge of that window it captures the data pins into a register. A write first spends one cycle with the RAM selected and the write data already driven. It then holds the strobe low for the pulse width. Afterwards it keeps the data and the select for a hold period with the strobe high again.

The output enable stays high for the whole write, so the RAM never drives the pins while the controller does. After every access the RAM is deselected for a recovery period. The acknowledge pulses for one cycle, at the start of that recovery period.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, ram_en_n is 1, ram_en is 0, ram_we_n is 1, ram_oe_n is 1, ram_dq_oe is 0 and ack is 0.
- R2: A read keeps the RAM selected (ram_en_n = 0 and ram_en = 1) with ram_we_n = 1 for max(T_RD, T_CYC) cycles. On the last edge of that window, rd_data takes the value on ram_dq_in.
- R3: During a read, ram_oe_n is low for exactly max(T_RD, T_CYC) consecutive cycles, and never fewer than T_RD.
- R4: A write selects the RAM for one setup cycle with ram_we_n = 1, then holds ram_we_n low for exactly T_WP cycles. It then keeps the RAM selected, with ram_we_n = 1 and ram_dq_oe = 1, for max(T_WH, T_CYC-1-T_WP) cycles. With the defaults the write is selected for 6 cycles in total.
- R5: ram_oe_n stays 1 throughout a write, and ram_dq_oe is never 1 while ram_oe_n is 0.
- R6: ram_addr does not change while the RAM is selected, and ram_dq_out does not change while ram_dq_oe is 1.
- R7: After each access the RAM is deselected for at least T_REC cycles before the next access starts.
- R8: ack is high for exactly one cycle per transaction, in the first cycle after the select drops. For a read, rd_data holds the captured word in that cycle.
- R9: req_ready is 1 only while the controller is idle. A request presented while req_ready is 0, and withdrawn before req_ready returns, causes no access and no write.
- R10: ram_addr and ram_dq_out carry the req_addr and req_wdata accepted with the request, on all 15 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read word |
| ram_addr | output | AW | RAM address lines |
| ram_en_n | output | 1 | Active-low chip select |
| ram_en | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | DW | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable of the data bus drivers |
| ram_dq_in | input | DW | Data read from the RAM pins |

## Verification
A state register that skips or repeats a phase shows up at once as a select, strobe or output-enable run of the wrong length. The bench measures each run on the cycle the signal returns high. A counter loaded with the wrong value stretches or shortens those same runs in the first access that uses it. A fault in the bus-enable decode appears as driver enable overlapping a low output enable in that same cycle. A stale address or data register is caught when the word read back differs from the arithmetic pattern written earlier.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSET,
      ST_WPUL,
      ST_WHLD,
      ST_REC
   } asram_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int CW     = 3,
   parameter int LEN_RD = 4,
   parameter int LEN_WP = 4,
   parameter int LEN_WH = 1,
   parameter int LEN_RC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          tmr_zero,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          take,
   output logic          capture,
   output logic          idle,
   output logic          sel,
   output logic          we_n,
   output logic          oe_n,
   output logic          dq_oe,
   output logic          ack
);
   localparam logic [CW-1:0] LD_RD = CW'(LEN_RD - 1);
   localparam logic [CW-1:0] LD_WP = CW'(LEN_WP - 1);
   localparam logic [CW-1:0] LD_WH = CW'(LEN_WH - 1);
   localparam logic [CW-1:0] LD_RC = CW'(LEN_RC - 1);

   asram_st_t st_q, st_d;
   logic      ack_q, ack_d;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      take     = 1'b0;
      capture  = 1'b0;
      ack_d    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               take = 1'b1;
               if (req_write) begin
                  st_d = ST_WSET;
               end else begin
                  st_d     = ST_RD;
                  tmr_load = 1'b1;
                  tmr_val  = LD_RD;
               end
            end
         end
         ST_RD: begin
            if (tmr_zero) begin
               capture  = 1'b1;
               ack_d    = 1'b1;
               st_d     = ST_REC;
               tmr_load = 1'b1;
               tmr_val  = LD_RC;
            end
         end
         ST_WSET: begin
            st_d     = ST_WPUL;
            tmr_load = 1'b1;
            tmr_val  = LD_WP;
         end
         ST_WPUL: begin
            if (tmr_zero) begin
               st_d     = ST_WHLD;
               tmr_load = 1'b1;
               tmr_val  = LD_WH;
            end
         end
         ST_WHLD: begin
            if (tmr_zero) begin
               ack_d    = 1'b1;
               st_d     = ST_REC;
               tmr_load = 1'b1;
               tmr_val  = LD_RC;
            end
         end
         ST_REC: begin
            if (tmr_zero) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ack_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ack_q <= ack_d;
      end
   end

   always_comb begin
      idle  = (st_q == ST_IDLE);
      sel   = (st_q == ST_RD) || (st_q == ST_WSET) ||
              (st_q == ST_WPUL) || (st_q == ST_WHLD);
      we_n  = (st_q != ST_WPUL);
      oe_n  = (st_q != ST_RD);
      dq_oe = (st_q == ST_WSET) || (st_q == ST_WPUL) || (st_q == ST_WHLD);
   end

   assign ack = ack_q;
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] ram_dq_in,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_dq_out,
   output logic [DW-1:0] rd_data
);
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdat_q;
   logic [DW-1:0] rdat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
      end else if (take) begin
         addr_q <= req_addr;
         wdat_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (capture) begin
         rdat_q <= ram_dq_in;
      end
   end

   assign ram_addr   = addr_q;
   assign ram_dq_out = wdat_q;
   assign rd_data    = rdat_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int AW    = 15,
   parameter int DW    = 8,
   parameter int T_RD  = 4,
   parameter int T_CYC = 4,
   parameter int T_WP  = 4,
   parameter int T_DS  = 3,
   parameter int T_WH  = 1,
   parameter int T_REC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          ack,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] ram_addr,
   output logic          ram_en_n,
   output logic          ram_en,
   output logic          ram_we_n,
   output logic          ram_oe_n,
   output logic [DW-1:0] ram_dq_out,
   output logic          ram_dq_oe,
   input  logic [DW-1:0] ram_dq_in
);
   localparam int LEN_RD  = imax(T_RD, T_CYC);
   localparam int LEN_WH  = imax(T_WH, T_CYC - 1 - T_WP);
   localparam int LEN_MAX = imax(imax(LEN_RD, T_WP), imax(LEN_WH, T_REC));
   localparam int CW      = imax(1, $clog2(LEN_MAX + 1));

   initial begin
      assert (AW >= 1 && DW >= 1) else $fatal(1, "asram_ctrl: bad widths");
      assert (T_RD >= 1 && T_CYC >= 1) else $fatal(1, "asram_ctrl: bad read timing");
      assert (T_WP >= 1 && T_WH >= 1 && T_REC >= 1) else $fatal(1, "asram_ctrl: bad write timing");
      assert (T_DS <= T_WP + 1) else $fatal(1, "asram_ctrl: data setup exceeds drive window");
   end

   logic          tmr_load, tmr_zero, take, capture, sel;
   logic [CW-1:0] tmr_val;

   asram_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   asram_fsm #(
      .CW     (CW),
      .LEN_RD (LEN_RD),
      .LEN_WP (T_WP),
      .LEN_WH (LEN_WH),
      .LEN_RC (T_REC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_zero  (tmr_zero),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .take      (take),
      .capture   (capture),
      .idle      (req_ready),
      .sel       (sel),
      .we_n      (ram_we_n),
      .oe_n      (ram_oe_n),
      .dq_oe     (ram_dq_oe),
      .ack       (ack)
   );

   asram_datapath #(.AW(AW), .DW(DW)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ram_dq_in  (ram_dq_in),
      .ram_addr   (ram_addr),
      .ram_dq_out (ram_dq_out),
      .rd_data    (rd_data)
   );

   assign ram_en_n = ~sel;
   assign ram_en   = sel;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int AW   = 15,
   parameter int DW   = 8,
   parameter int T_RD = 4,
   parameter int T_WP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic [AW-1:0] ram_addr,
   input logic          ram_en_n,
   input logic          ram_en,
   input logic          ram_we_n,
   input logic          ram_oe_n,
   input logic [DW-1:0] ram_dq_out,
   input logic          ram_dq_oe
);
   logic        selw;
   logic [15:0] we_lo_cnt, oe_lo_cnt;

   assign selw = !ram_en_n && ram_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_lo_cnt <= '0;
      end else begin
         we_lo_cnt <= ram_we_n ? '0 : ((we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 1'b1);
         oe_lo_cnt <= ram_oe_n ? '0 : ((oe_lo_cnt == 16'hFFFF) ? oe_lo_cnt : oe_lo_cnt + 1'b1);
      end
   end

   AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> selw); // R4
   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> (we_lo_cnt >= T_WP)); // R4
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> (ram_dq_oe && selw)); // R4
   AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_oe_n) |-> (oe_lo_cnt >= T_RD)); // R3
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> ram_oe_n); // R5
   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (selw && $past(selw)) |-> $stable(ram_addr)); // R6
   AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out)); // R6
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R8
   AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !selw); // R8
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW), .T_RD(T_RD), .T_WP(T_WP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack        (ack),
   .ram_addr   (ram_addr),
   .ram_en_n   (ram_en_n),
   .ram_en     (ram_en),
   .ram_we_n   (ram_we_n),
   .ram_oe_n   (ram_oe_n),
   .ram_dq_out (ram_dq_out),
   .ram_dq_oe  (ram_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int EXP_RD_LEN = 4;
   localparam int EXP_WP     = 4;
   localparam int EXP_WR_LEN = 6;
   localparam int T_REC      = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, ack, ram_en_n, ram_en, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [DW-1:0] rd_data, ram_dq_out, ram_dq_in;
   logic [AW-1:0] ram_addr;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   asram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .ack(ack), .rd_data(rd_data), .ram_addr(ram_addr), .ram_en_n(ram_en_n),
      .ram_en(ram_en), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
      .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
   );

   assign ram_dq_in = (!ram_en_n && ram_en && ram_we_n && !ram_oe_n) ? mem[ram_addr[7:0]] : 8'hEE;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] addr_of(input int i);
      return AW'((i << 9) | ((i * 3) & 8'hFF));
   endfunction

   function automatic logic [DW-1:0] pat_of(input int i);
      return DW'((i * 37 + 5) & 8'hFF);
   endfunction

   // waveform monitor
   bit          p_sel = 0, p_we_n = 1, p_oe_n = 1, p_ack = 0, saw_we = 0;
   int          sel_run = 0, gap_run = 100, we_run = 0, oe_run = 0, strobes = 0;
   logic [AW-1:0] start_addr, w_addr;
   logic [DW-1:0] w_data;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit s = !ram_en_n && ram_en;
         if (s) begin
            if (!p_sel) begin
               chk(gap_run >= T_REC, "R7 deselect gap", gap_run, T_REC);
               start_addr = ram_addr;
               saw_we = 0;
               sel_run = 0;
            end
            sel_run++;
            chk(ram_addr == start_addr, "R6 address steady", ram_addr, start_addr);
         end else begin
            if (p_sel) begin
               chk(sel_run == (saw_we ? EXP_WR_LEN : EXP_RD_LEN),
                   saw_we ? "R4 write select length" : "R2 read select length",
                   sel_run, saw_we ? EXP_WR_LEN : EXP_RD_LEN);
               gap_run = 0;
            end
            gap_run++;
         end
         if (ram_dq_oe && !ram_oe_n) chk(0, "R5 bus fight", 1, 0);
         if (!ram_we_n) begin
            if (!p_we_n) chk(ram_dq_out == w_data, "R6 write data steady", ram_dq_out, w_data);
            saw_we = 1;
            we_run++;
            w_data = ram_dq_out;
            w_addr = ram_addr;
            chk(ram_oe_n, "R5 output enable high in write", ram_oe_n, 1);
         end else if (!p_we_n) begin
            chk(we_run == EXP_WP, "R4 strobe width", we_run, EXP_WP);
            chk(ram_dq_oe && s, "R4 hold after strobe", {ram_dq_oe, s}, 3);
            mem[w_addr[7:0]] = w_data;
            strobes++;
            we_run = 0;
         end
         if (!ram_oe_n) oe_run++;
         else if (!p_oe_n) begin
            chk(oe_run == EXP_RD_LEN, "R3 output enable width", oe_run, EXP_RD_LEN);
            oe_run = 0;
         end
         if (ack) begin
            chk(!p_ack, "R8 ack single cycle", p_ack, 0);
            chk(!s, "R8 ack after deselect", s, 0);
         end
         p_sel = s; p_we_n = ram_we_n; p_oe_n = ram_oe_n; p_ack = ack;
      end
   end

   task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit do_rchk, input logic [DW-1:0] exp_r);
      @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!ack) @(negedge clk);
      if (w) begin
         chk(w_addr == a, "R10 write address", w_addr, a);
         chk(mem[a[7:0]] == d, "R10 write data", mem[a[7:0]], d);
      end else if (do_rchk) begin
         chk(rd_data == exp_r, "R2 read data", rd_data, exp_r);
      end
   endtask

   bit done = 0;

   initial begin
      repeat (2000 * 10) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 8'h00;
      repeat (3) @(negedge clk);
      chk({ram_en_n, ram_en, ram_we_n, ram_oe_n, ram_dq_oe, ack} == 6'b101100,
          "R1 reset outputs", {ram_en_n, ram_en, ram_we_n, ram_oe_n, ram_dq_oe, ack}, 6'b101100);
      rst_n = 1;
      @(negedge clk);
      chk({ram_en_n, ram_en, ram_we_n, ram_oe_n, ram_dq_oe, ack} == 6'b101100,
          "R1 outputs after release", {ram_en_n, ram_en, ram_we_n, ram_oe_n, ram_dq_oe, ack}, 6'b101100);
      chk(req_ready, "R9 ready when idle", req_ready, 1);

      for (int i = 0; i < 64; i++) access(1, addr_of(i), pat_of(i), 0, 0);
      for (int i = 0; i < 64; i++) access(0, addr_of(i), 0, 1, pat_of(i));
      for (int i = 0; i < 16; i++) begin
         access(1, addr_of(i), ~pat_of(i), 0, 0);
         access(0, addr_of(63 - i), 0, 1, pat_of(63 - i));
         access(0, addr_of(i), 0, 1, ~pat_of(i));
      end
      chk(strobes == 80, "R4 strobe count", strobes, 80);

      // request while busy is not taken
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = addr_of(5); req_wdata = 8'h11;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1; req_addr = 15'h40F0; req_wdata = 8'h5A;
      chk(!req_ready, "R9 ready low while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 0;
      while (!ack) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(ram_en_n && !ram_en, "R9 no access from busy request", ram_en, 0);
      end
      chk(strobes == 81, "R9 strobe count", strobes, 81);
      access(0, 15'h40F0, 0, 1, 8'h00);
      access(0, addr_of(5), 0, 1, 8'h11);

      repeat (4) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule